// File: doc/BRIEF.md
# Synchronous Burst SRAM

A small, synthesizable synchronous SRAM with burst addressing. The array holds `2**ADDR_W` words, and each word is split into `LANES` byte lanes of `LANE_W` bits. With the default values the array is 256 words of 18 bits in two 9-bit lanes. Chip select, both address strobes, advance, the write controls, the address and the write data are all sampled on the rising clock edge. A cycle that loads an address starts a burst. Later cycles run through the other three words of the aligned 4-word block, using a 2-bit counter that counts in either linear or interleaved order.

A static mode input chooses the read timing. In flow-through mode the array output goes straight to the pins. In pipelined mode the data passes through one more rising-edge register. A deselect command travels through the same pipeline as a read, so the outputs turn off exactly as late as read data would have turned on. Output enable and the sleep input act without waiting for a clock. The high-impedance state appears as `dq_drive` low, with `dq` forced to zero. A pad ring outside the block turns this into a real tri-state.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dq_drive` is 0 and `dq` is 0, and no burst is active. A cycle with no strobe then reads nothing.
- R2: `stb_a` with `cs` high always starts a read at `addr`, whatever the write controls are. It wins over `stb_b` in the same cycle, and nothing is written in that cycle.
- R3: `stb_b` with `cs` high loads `addr` and performs a write when `gwe` is high or when `bwe` is high with at least one `bsel` bit set. Otherwise it performs a read. Burst cycles that follow decide between read and write in the same way. Write cycles never drive the outputs.
- R4: In a byte write (`bwe` high, `gwe` low), a lane is written only when its select bit is set. Bit i of `bsel` controls `wdata` bits [9i+8:9i], and the other lanes keep their contents.
- R5: When `gwe` is high in a write cycle, every lane is written, whatever `bwe` and `bsel` are.
- R6: With `pipe_mode` low, read data for a command sampled on edge k is driven right after edge k. A 4-word burst therefore takes 2-1-1-1 clocks.
- R7: With `pipe_mode` high, read data for a command sampled on edge k is driven after edge k+1. A 4-word burst therefore takes 3-1-1-1 clocks.
- R8: With `lin_order` high, the n-th burst word lies at offset (start + n) mod 4 within its 4-word block. The upper address bits never change.
- R9: With `lin_order` low, the n-th burst word lies at offset (start XOR n) within its 4-word block.
- R10: In a cycle with no strobe during a burst, `adv` high steps the counter and `adv` low repeats the current word. `adv` has no effect in a cycle where a strobe loads a new address.
- R11: A strobe with `cs` low is a deselect and ends the burst. In pipelined mode the outputs keep driving after the first rising edge that follows the deselect and turn off after the second. In flow-through mode they turn off after the first.
- R12: `oe` low stops the outputs from driving at once, without waiting for a clock. When `oe` returns high, the pending data reappears.
- R13: While `sleep` is high, the outputs do not drive, writes are ignored and all internal state is held. Operation resumes on the first edge after `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| stb_a | input | 1 | Read-only address strobe, highest priority |
| stb_b | input | 1 | Read/write address strobe |
| adv | input | 1 | Step the burst counter |
| bwe | input | 1 | Byte-write enable |
| bsel | input | LANES | Per-lane write select |
| gwe | input | 1 | Global write, all lanes |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power hold |
| dq | output | LANES*LANE_W | Read data, zero when not driving |
| dq_drive | output | 1 | High when `dq` would be driven onto the bus |

## Verification
The latency and deselect properties assume that `pipe_mode` and `lin_order` only change while no read or deselect is still in the output pipeline. They also assume that `sleep` is either held or released for whole cycles across the window they observe. The stimulus changes the two mode inputs only after the scoreboard queue has drained and a few idle cycles have passed. It toggles `oe` and `sleep` between clock edges and always releases `sleep` together with a deselect, so the state held during sleep is known when operation resumes.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sram_op_e;
endpackage

// File: rtl/sbsram_burst_ctr.sv
`timescale 1ns/1ps
module sbsram_burst_ctr #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              stop,
  input  logic              adv,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active
);
  localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] off;
  logic               act_q;

  // next offset: step only inside a running burst and never on a load
  always_comb begin
    cnt_nx = cnt_q;
    if (act_q && adv && !load && !stop) cnt_nx = cnt_q + ONE;
    off = linear ? (base_q[BURST_W-1:0] + cnt_nx) : (base_q[BURST_W-1:0] ^ cnt_nx);
    cur_addr = load ? addr_in : {base_q[ADDR_W-1:BURST_W], off};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (en) begin
      if (stop) begin
        act_q <= 1'b0;
      end else if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
        act_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign active = act_q;

  // R10: advance steps the counter by one, wrapping in the block
  a_r10_adv_steps: assert property (@(posedge clk) disable iff (rst)
    (en && act_q && adv && !load && !stop) |=> (cnt_q == $past(cnt_q) + ONE));
  // R10: no advance keeps the same word
  a_r10_hold_word: assert property (@(posedge clk) disable iff (rst)
    (en && act_q && !adv && !load && !stop) |=> ($stable(cnt_q) && $stable(base_q)));
  // R8: every load restarts the count at the loaded word
  a_r8_load_restarts: assert property (@(posedge clk) disable iff (rst)
    (en && load && !stop) |=> (cnt_q == '0 && act_q));
  // R11: a deselect ends the burst
  a_r11_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (en && stop) |=> !act_q);
endmodule

// File: rtl/sbsram_lane_mem.sv
`timescale 1ns/1ps
module sbsram_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [LANES-1:0]         we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one block-RAM column per lane, registered read, read-before-write
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_r;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        q_r <= mem[addr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = q_r;
  end
endmodule

// File: rtl/sbsram_out_stage.sv
`timescale 1ns/1ps
module sbsram_out_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pipe_mode,
  input  logic          is_read,
  input  logic [DW-1:0] mem_q,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] dq,
  output logic          dq_drive
);
  logic          drv1_q;
  logic          drv2_q;
  logic [DW-1:0] q2_q;
  logic          core_drv;
  logic [DW-1:0] core_q;

  // drive flag follows the same stages as the data, so a deselect
  // shuts the pins off exactly as late as a read turns them on
  always_ff @(posedge clk) begin
    if (rst) begin
      drv1_q <= 1'b0;
      drv2_q <= 1'b0;
      q2_q   <= '0;
    end else if (en) begin
      drv1_q <= is_read;
      drv2_q <= drv1_q;
      q2_q   <= mem_q;
    end
  end

  always_comb begin
    core_drv = pipe_mode ? drv2_q : drv1_q;
    core_q   = pipe_mode ? q2_q   : mem_q;
  end

  assign dq_drive = core_drv & oe & ~sleep;
  assign dq       = dq_drive ? core_q : '0;

  // R6: flow-through read drives right after its own edge
  a_r6_flow_latency: assert property (@(posedge clk) disable iff (rst)
    (en && !pipe_mode && is_read) |=> (pipe_mode || core_drv));
  // R7: pipelined read drives one edge later
  a_r7_pipe_latency: assert property (@(posedge clk) disable iff (rst)
    (en && pipe_mode && is_read) ##1 (en && pipe_mode) |=> core_drv);
  // R11: pipelined deselect turns the pins off after the second edge
  a_r11_dcd_off: assert property (@(posedge clk) disable iff (rst)
    (en && pipe_mode && !is_read) ##1 (en && pipe_mode) |=> !core_drv);
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    stb_a,
  input  logic                    stb_b,
  input  logic                    adv,
  input  logic                    bwe,
  input  logic [LANES-1:0]        bsel,
  input  logic                    gwe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    lin_order,
  input  logic                    pipe_mode,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq,
  output logic                    dq_drive
);
  localparam int DW = LANES * LANE_W;

  logic              run;
  logic              ld_a;
  logic              ld_b;
  logic              stop;
  logic              wr_req;
  logic              act;
  logic              is_read;
  sram_op_e          op;
  logic [LANES-1:0]  we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DW-1:0]     mem_q;

  assign run = ~sleep;

  // command decode: strobe A > strobe B > burst continuation
  always_comb begin
    ld_a   = cs & stb_a;
    ld_b   = cs & stb_b & ~stb_a;
    stop   = (stb_a | stb_b) & ~cs;
    wr_req = gwe | (bwe & (|bsel));
    if (stop)              op = OP_DESEL;
    else if (ld_a)         op = OP_READ;
    else if (ld_b || act)  op = wr_req ? OP_WRITE : OP_READ;
    else                   op = OP_IDLE;
    for (int i = 0; i < LANES; i++)
      we[i] = run && (op == OP_WRITE) && (gwe || (bwe && bsel[i]));
    is_read = (op == OP_READ);
  end

  sbsram_burst_ctr #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .en      (run),
    .load    (ld_a | ld_b),
    .stop    (stop),
    .adv     (adv),
    .linear  (lin_order),
    .addr_in (addr),
    .cur_addr(cur_addr),
    .active  (act)
  );

  sbsram_lane_mem #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_mem (
    .clk  (clk),
    .en   (run),
    .we   (we),
    .addr (cur_addr),
    .wdata(wdata),
    .rdata(mem_q)
  );

  sbsram_out_stage #(
    .DW(DW)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .en       (run),
    .pipe_mode(pipe_mode),
    .is_read  (is_read),
    .mem_q    (mem_q),
    .oe       (oe),
    .sleep    (sleep),
    .dq       (dq),
    .dq_drive (dq_drive)
  );

  // R2: strobe A never writes
  a_r2_stb_a_no_write: assert property (@(posedge clk) disable iff (rst)
    (stb_a && cs) |-> (we == '0));
  // R4: byte write touches exactly the selected lanes
  a_r4_lane_select: assert property (@(posedge clk) disable iff (rst)
    (run && stb_b && cs && !stb_a && bwe && !gwe) |-> (we == bsel));
  // R5: global write covers every lane
  a_r5_global_all: assert property (@(posedge clk) disable iff (rst)
    (run && stb_b && cs && !stb_a && gwe) |-> (&we));
  // R13: no write while asleep
  a_r13_sleep_no_write: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (we == '0));
endmodule

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int AW = 8;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, stb_a = 1'b0, stb_b = 1'b0, adv = 1'b0, bwe = 1'b0, gwe = 1'b0;
  logic [LN-1:0] bsel = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic lin_order = 1'b1, pipe_mode = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] dq;
  logic dq_drive;

  always #2.5 clk = ~clk;

  sync_burst_sram u_dut (
    .clk(clk), .rst(rst), .cs(cs), .stb_a(stb_a), .stb_b(stb_b), .adv(adv),
    .bwe(bwe), .bsel(bsel), .gwe(gwe), .addr(addr), .wdata(wdata),
    .lin_order(lin_order), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
    .dq(dq), .dq_drive(dq_drive)
  );

  typedef struct {
    int            due;
    bit            drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] ref_mem [256];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_act = 1'b0;
  int            cyc = 0;
  int            n_run = 0;
  int            n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply one command and push what the pins must show
  task automatic step(input bit sa, input bit sb, input bit c, input bit ad,
                      input bit bw, input logic [1:0] sel, input bit gw,
                      input logic [7:0] a, input logic [17:0] d,
                      input string tag, input bit chk);
    int kind;
    logic [7:0] ea;
    exp_t it;
    @(negedge clk);
    stb_a = sa; stb_b = sb; cs = c; adv = ad; bwe = bw; bsel = sel; gwe = gw;
    addr = a; wdata = d;
    kind = 0;
    if ((sa || sb) && !c) begin kind = 3; m_act = 1'b0; end
    else if (sa) begin kind = 1; m_base = a; m_cnt = 2'd0; m_act = 1'b1; end
    else if (sb) begin
      m_base = a; m_cnt = 2'd0; m_act = 1'b1;
      kind = (gw || (bw && sel != 2'b00)) ? 2 : 1;
    end else if (m_act) begin
      if (ad) m_cnt = m_cnt + 2'd1;
      kind = (gw || (bw && sel != 2'b00)) ? 2 : 1;
    end
    ea = {m_base[7:2], lin_order ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
    if (kind == 2)
      for (int i = 0; i < LN; i++)
        if (gw || (bw && sel[i])) ref_mem[ea][i*LW +: LW] = d[i*LW +: LW];
    if (chk) begin
      it.due  = cyc + (pipe_mode ? 2 : 1);
      it.drv  = (kind == 1);
      it.data = (kind == 1) ? ref_mem[ea] : '0;
      it.tag  = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic rd_a(input logic [7:0] a, input string tag);
    step(1, 0, 1, 0, 0, 2'b00, 0, a, '0, tag, 1);
  endtask
  task automatic wr_b(input logic [7:0] a, input logic [17:0] d, input bit bw,
                      input logic [1:0] sel, input bit gw, input string tag);
    step(0, 1, 1, 0, bw, sel, gw, a, d, tag, 1);
  endtask
  task automatic cont(input bit ad, input bit gw, input logic [17:0] d,
                      input string tag, input bit chk);
    step(0, 0, 1, ad, 0, 2'b00, gw, 8'h00, d, tag, chk);
  endtask
  task automatic desel(input string tag, input bit chk);
    step(1, 0, 0, 0, 0, 2'b00, 0, 8'h00, '0, tag, chk);
  endtask
  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare the pins with the queue head when it falls due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() != 0 && sbq[0].due <= cyc) begin
        exp_t it;
        it = sbq.pop_front();
        check(it.tag, {13'b0, dq_drive, dq}, {13'b0, it.drv, it.data});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset drive", {31'b0, dq_drive}, 32'd0);
    check("R1 reset data", {14'b0, dq}, 32'd0);
    step(0, 0, 1, 1, 0, 2'b00, 0, 8'h00, '0, "R1 idle no burst", 1);

    // flow-through, linear: global-write burst then read it back
    wr_b(8'h12, 18'h11111, 0, 2'b00, 1, "R3 write start");
    cont(1, 1, 18'h22222, "R3 write burst", 1);
    cont(1, 1, 18'h33333, "R3 write burst", 1);
    cont(1, 1, 18'h04444, "R3 write burst", 1);
    rd_a(8'h12, "R6 flow first word");
    cont(1, 0, '0, "R8 linear word1", 1);
    cont(1, 0, '0, "R8 linear word2", 1);
    cont(1, 0, '0, "R8 linear wrap", 1);
    cont(0, 0, '0, "R10 adv low repeat", 1);
    step(1, 0, 1, 1, 0, 2'b00, 0, 8'h13, '0, "R10 adv ignored on load", 1);

    // byte writes against global writes
    wr_b(8'h12, 18'h3FFFF, 1, 2'b01, 0, "R4 low lane write");
    rd_a(8'h12, "R4 low lane only");
    wr_b(8'h13, 18'h15555, 1, 2'b10, 0, "R4 high lane write");
    rd_a(8'h13, "R4 high lane only");
    wr_b(8'h10, 18'h2ABCD, 1, 2'b01, 1, "R5 override select");
    rd_a(8'h10, "R5 all lanes written");
    wr_b(8'h11, 18'h1F0F0, 0, 2'b00, 1, "R5 without bwe");
    rd_a(8'h11, "R5 all lanes written");
    step(0, 1, 1, 0, 1, 2'b00, 0, 8'h12, 18'h00000, "R3 no lane selected reads", 1);
    step(1, 1, 1, 0, 1, 2'b11, 1, 8'h12, 18'h00000, "R2 strobe A wins", 1);
    rd_a(8'h12, "R2 nothing written");
    desel("R11 flow deselect", 1);
    step(0, 0, 1, 1, 0, 2'b00, 0, 8'h00, '0, "R11 stays off", 1);
    drain();

    // interleaved order from offset 1: 1,0,3,2
    lin_order = 1'b0;
    rd_a(8'h11, "R9 interleaved word0");
    cont(1, 0, '0, "R9 interleaved word1", 1);
    cont(1, 0, '0, "R9 interleaved word2", 1);
    cont(1, 0, '0, "R9 interleaved word3", 1);
    desel("R11 deselect", 1);
    drain();

    // pipelined mode
    lin_order = 1'b1;
    pipe_mode = 1'b1;
    drain();
    rd_a(8'h10, "R7 pipe first word");
    cont(1, 0, '0, "R11 still driving after deselect edge", 1);
    desel("R11 off after second edge", 1);
    step(0, 0, 1, 0, 0, 2'b00, 0, 8'h00, '0, "R11 remains off", 1);
    wr_b(8'h14, 18'h0ABCD, 0, 2'b00, 1, "R7 pipe write no drive");
    rd_a(8'h14, "R7 pipe read back");
    cont(1, 0, '0, "R7 pipe burst beat", 1);
    drain();

    // output enable
    rd_a(8'h12, "R7 pipe read");
    cont(0, 0, '0, "R12", 0);
    cont(0, 0, '0, "R12", 0);
    cont(0, 0, '0, "R12", 0);
    #1.5;
    oe = 1'b0;
    #0.2;
    check("R12 oe low stops drive", {13'b0, dq_drive, dq}, 32'd0);
    oe = 1'b1;
    #0.2;
    check("R12 oe high restores", {13'b0, dq_drive, dq}, {13'b0, 1'b1, ref_mem[8'h12]});

    // sleep: hold state, ignore a write
    @(negedge clk);
    sleep = 1'b1;
    stb_b = 1'b1; cs = 1'b1; gwe = 1'b1; addr = 8'h12; wdata = '0;
    #1;
    check("R13 asleep no drive", {31'b0, dq_drive}, 32'd0);
    @(negedge clk);
    #1;
    check("R13 still asleep", {31'b0, dq_drive}, 32'd0);
    sleep = 1'b0;
    stb_a = 1'b1; stb_b = 1'b0; cs = 1'b0; gwe = 1'b0;
    m_act = 1'b0;
    rd_a(8'h12, "R13 write ignored in sleep");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule